// File: doc/BRIEF.md
# Instruction Compaction Encoder

This unit takes one 128-bit native instruction and tries to rewrite it as a 64-bit compact instruction. Several multi-bit keys are pulled out of the wide word: a control key, a datatype key, a subregister key and two source-operand keys. Each key is searched in a 32-entry lookup table, and a hit is replaced by its 5-bit table index. Compaction succeeds only if every key hits, any immediate operand fits the short sign-replicated form, the opcode is not a flow-control opcode, and the input is not already compact. A few scalar fields (opcode, register numbers and modifiers) are copied straight across.

The lookup tables are parameters. Two table sets exist, and one parameter picks between an older and a newer variant. The variants differ in how the flag subregister is carried. The result is registered: one cycle after an input is presented, the unit raises a valid strobe and a success flag. It loads the compact word only on success, so a failed attempt leaves the previously emitted word on the output.

Top module: `cmpct_encoder`

## Requirements
- R1: While reset is asserted, out_valid and out_ok are 0 and out_word is all zeros.
- R2: The control key is {in_word[31], in_word[23:8]} (17 bits, zero-extended) in the older variant (NEWER=0). In the newer variant (NEWER=1) it is {in_word[90:89], in_word[31], in_word[23:8]}. The matching index goes to out_word[12:8].
- R3: The datatype key is {in_word[63:61], in_word[46:32]}, and its index goes to out_word[17:13].
- R4: The subregister key is {in_word[100:96], in_word[68:64], in_word[52:48]}, with the top five bits forced to zero when an immediate is present. Its index goes to out_word[22:18].
- R5: The source-0 key is in_word[88:77] and the source-1 key is in_word[120:109]. Both are searched in the same source table, and their indices go to out_word[34:30] and out_word[39:35].
- R6: If any required key misses, out_ok is 0 and out_word keeps its previous value.
- R7: If a key matches several table entries, the lowest entry index is used.
- R8: An immediate is present when in_word[42:41] or in_word[44:43] equals 2'b11. Its value is in_word[127:96]. It is compactable only if value bits 31:12 are all zeros or all ones; otherwise compaction fails.
- R9: With an immediate, no source-1 lookup is made. Immediate bits 12:8 become out_word[39:35], and immediate bits 7:0 become out_word[63:56].
- R10: Opcodes (in_word[6:0]) 0x22, 0x24, 0x25, 0x26, 0x27 and 0x2A are never compacted.
- R11: An input with in_word[29] set is not compacted. Every successful output has out_word[29] set.
- R12: In the older variant, in_word[89] is copied to out_word[28]. In the newer variant, out_word[28] is 0 and in_word[90:89] take part only through the control key.
- R13: The following fields are copied: opcode to out_word[6:0], in_word[30] to out_word[7], in_word[28] to out_word[23], in_word[27:24] to out_word[27:24], in_word[60:53] to out_word[47:40], in_word[76:69] to out_word[55:48], and in_word[108:101] to out_word[63:56] when there is no immediate.
- R14: out_valid is high exactly in the cycle after a cycle with in_valid high. out_ok is never high without out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_word | input | 128 | Native instruction |
| out_valid | output | 1 | Result of the previous cycle's instruction |
| out_ok | output | 1 | Compaction succeeded |
| out_word | output | 64 | Compact instruction; held after a failure |

## Verification
The hardest situations to reach are a wide word in which every table key hits but one gate still refuses, and a key that matches two table entries at once. The bench supplies its own tables and builds each instruction from table indices, so every lookup is known to hit. It then breaks exactly one condition in each case: one key bit, one immediate bit above bit 11, a forbidden opcode or the compaction flag. A deliberate duplicate entry in the source table exposes which index wins. A key that differs only in bits 90:89 shows that only the newer variant looks at them.

// File: rtl/cmpct_pkg.sv
package cmpct_pkg;
   localparam int IDX_W      = 5;
   localparam int N_ENT      = 1 << IDX_W;
   localparam int INST_W     = 128;
   localparam int CMP_W      = 64;
   localparam int OP_W       = 7;
   localparam int CTRL_W     = 19;
   localparam int CTRL_W_OLD = 17;
   localparam int DT_W       = 18;
   localparam int SR_W       = 15;
   localparam int SR_PART_W  = 5;
   localparam int SRC_W      = 12;
   localparam int IMM_W      = 32;
   localparam int REG_W      = 8;
   localparam int COND_W     = 4;
   localparam int N_NOCMP    = 6;

   // compact word field positions (low bit of each field)
   localparam int CW_OPC  = 0;
   localparam int CW_DBG  = 7;
   localparam int CW_CTRL = 8;
   localparam int CW_DT   = 13;
   localparam int CW_SR   = 18;
   localparam int CW_ACC  = 23;
   localparam int CW_COND = 24;
   localparam int CW_FSUB = 28;
   localparam int CW_CMPT = 29;
   localparam int CW_S0   = 30;
   localparam int CW_S1   = 35;
   localparam int CW_DREG = 40;
   localparam int CW_S0R  = 48;
   localparam int CW_S1R  = 56;

   localparam logic [1:0] FILE_IMM = 2'b11;

   typedef logic [N_ENT-1:0][CTRL_W-1:0] ctrl_tab_t;
   typedef logic [N_ENT-1:0][DT_W-1:0]   dt_tab_t;
   typedef logic [N_ENT-1:0][SR_W-1:0]   sr_tab_t;
   typedef logic [N_ENT-1:0][SRC_W-1:0]  src_tab_t;
   typedef logic [N_NOCMP-1:0][OP_W-1:0] op_list_t;

   localparam op_list_t NOCMP_DFLT = {7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A};

   typedef struct packed {
      logic [CTRL_W-1:0] ctrl_key;
      logic [DT_W-1:0]   dt_key;
      logic [SR_W-1:0]   sr_key;
      logic [SRC_W-1:0]  s0_key;
      logic [SRC_W-1:0]  s1_key;
      logic [OP_W-1:0]   opc;
      logic              dbg;
      logic              acc;
      logic [COND_W-1:0] cond;
      logic              fsub;
      logic [REG_W-1:0]  dreg;
      logic [REG_W-1:0]  s0reg;
      logic [REG_W-1:0]  s1reg;
      logic [IDX_W-1:0]  imm_idx;
      logic              imm_present;
      logic              imm_fits;
      logic              pre_cmpt;
   } fields_t;

   function automatic ctrl_tab_t dflt_ctrl(input bit newer);
      ctrl_tab_t t;
      for (int i = 0; i < N_ENT; i++) begin
         t[i] = CTRL_W'(i * 41 + 2);
         if (newer) t[i][CTRL_W-1:CTRL_W_OLD] = 2'(i >> 3);
      end
      return t;
   endfunction

   function automatic dt_tab_t dflt_dt(input bit newer);
      dt_tab_t t;
      for (int i = 0; i < N_ENT; i++) begin
         t[i] = DT_W'(i * 13 + (newer ? 3 : 1));
         if (i >= N_ENT - 4) t[i][10:9] = FILE_IMM;
      end
      return t;
   endfunction

   function automatic sr_tab_t dflt_sr(input bit newer);
      sr_tab_t t;
      for (int i = 0; i < N_ENT; i++)
         t[i] = (i < N_ENT / 2) ? SR_W'(i * 9 + (newer ? 2 : 1))
                                : SR_W'((i << 10) | (i * 3));
      return t;
   endfunction

   function automatic src_tab_t dflt_src(input bit newer);
      src_tab_t t;
      for (int i = 0; i < N_ENT; i++)
         t[i] = SRC_W'(i * 97 + (newer ? 13 : 11));
      return t;
   endfunction
endpackage

// File: rtl/cmpct_lut_match.sv
module cmpct_lut_match #(
   parameter int KEY_W = 12,
   parameter int N     = 32,
   parameter int IW    = $clog2(N),
   parameter logic [N-1:0][KEY_W-1:0] TAB = '0
)(
   input  logic [KEY_W-1:0] key,
   output logic             hit,
   output logic [IW-1:0]    idx
);
   logic [N-1:0] eq;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = (TAB[g] == key);
   end

   // scan from the top so the lowest matching entry is the last written
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eq[i]) idx = IW'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/cmpct_key_extract.sv
module cmpct_key_extract
   import cmpct_pkg::*;
#(
   parameter bit       NEWER     = 1'b1,
   parameter op_list_t NOCMP_OPS = NOCMP_DFLT
)(
   input  logic [INST_W-1:0] in_word,
   output fields_t           fld,
   output logic              excluded
);
   logic [IMM_W-1:0]   imm;
   logic               imm_present;
   logic [N_NOCMP-1:0] op_hit;
   logic [SR_PART_W-1:0] sr_top;
   logic unused_bits;

   assign imm         = in_word[127:96];
   assign imm_present = (in_word[42:41] == FILE_IMM) || (in_word[44:43] == FILE_IMM);

   // control key layout depends on the variant
   if (NEWER) begin : g_ctrl_new
      assign fld.ctrl_key = {in_word[90:89], in_word[31], in_word[23:8]};
      assign fld.fsub     = 1'b0;
   end else begin : g_ctrl_old
      assign fld.ctrl_key = {{(CTRL_W - CTRL_W_OLD){1'b0}}, in_word[31], in_word[23:8]};
      assign fld.fsub     = in_word[89];
   end

   assign fld.dt_key = {in_word[63:61], in_word[46:32]};
   assign sr_top     = imm_present ? '0 : in_word[100:96];
   assign fld.sr_key = {sr_top, in_word[68:64], in_word[52:48]};
   assign fld.s0_key = in_word[88:77];
   assign fld.s1_key = in_word[120:109];

   assign fld.opc      = in_word[6:0];
   assign fld.dbg      = in_word[30];
   assign fld.pre_cmpt = in_word[29];
   assign fld.acc      = in_word[28];
   assign fld.cond     = in_word[27:24];
   assign fld.dreg     = in_word[60:53];
   assign fld.s0reg    = in_word[76:69];
   assign fld.s1reg    = imm_present ? imm[7:0] : in_word[108:101];
   assign fld.imm_idx  = imm[12:8];

   assign fld.imm_present = imm_present;
   assign fld.imm_fits    = (&imm[31:12]) || !(|imm[31:12]);

   for (genvar g = 0; g < N_NOCMP; g++) begin : g_excl
      assign op_hit[g] = (in_word[6:0] == NOCMP_OPS[g]);
   end
   assign excluded = |op_hit;

   assign unused_bits = ^{in_word[7], in_word[47], in_word[95:91]};
endmodule

// File: rtl/cmpct_word_pack.sv
module cmpct_word_pack
   import cmpct_pkg::*;
#(
   parameter bit NEWER = 1'b1
)(
   input  logic [OP_W-1:0]   opc,
   input  logic              dbg,
   input  logic [IDX_W-1:0]  ctrl_idx,
   input  logic [IDX_W-1:0]  dt_idx,
   input  logic [IDX_W-1:0]  sr_idx,
   input  logic              acc,
   input  logic [COND_W-1:0] cond,
   input  logic              fsub,
   input  logic [IDX_W-1:0]  s0_idx,
   input  logic [IDX_W-1:0]  s1_idx,
   input  logic [REG_W-1:0]  dreg,
   input  logic [REG_W-1:0]  s0reg,
   input  logic [REG_W-1:0]  s1reg,
   output logic [CMP_W-1:0]  word
);
   logic fsub_bit;

   if (NEWER) begin : g_fs_new
      logic unused_fsub;
      assign unused_fsub = fsub;
      assign fsub_bit    = 1'b0;
   end else begin : g_fs_old
      assign fsub_bit = fsub;
   end

   always_comb begin
      word = '0;
      word[CW_OPC  +: OP_W]   = opc;
      word[CW_DBG]            = dbg;
      word[CW_CTRL +: IDX_W]  = ctrl_idx;
      word[CW_DT   +: IDX_W]  = dt_idx;
      word[CW_SR   +: IDX_W]  = sr_idx;
      word[CW_ACC]            = acc;
      word[CW_COND +: COND_W] = cond;
      word[CW_FSUB]           = fsub_bit;
      word[CW_CMPT]           = 1'b1;
      word[CW_S0   +: IDX_W]  = s0_idx;
      word[CW_S1   +: IDX_W]  = s1_idx;
      word[CW_DREG +: REG_W]  = dreg;
      word[CW_S0R  +: REG_W]  = s0reg;
      word[CW_S1R  +: REG_W]  = s1reg;
   end
endmodule

// File: rtl/cmpct_encoder.sv
module cmpct_encoder
   import cmpct_pkg::*;
#(
   parameter bit        NEWER        = 1'b1,
   parameter ctrl_tab_t CTRL_TAB_OLD = dflt_ctrl(1'b0),
   parameter ctrl_tab_t CTRL_TAB_NEW = dflt_ctrl(1'b1),
   parameter dt_tab_t   DT_TAB_OLD   = dflt_dt(1'b0),
   parameter dt_tab_t   DT_TAB_NEW   = dflt_dt(1'b1),
   parameter sr_tab_t   SR_TAB_OLD   = dflt_sr(1'b0),
   parameter sr_tab_t   SR_TAB_NEW   = dflt_sr(1'b1),
   parameter src_tab_t  SRC_TAB_OLD  = dflt_src(1'b0),
   parameter src_tab_t  SRC_TAB_NEW  = dflt_src(1'b1),
   parameter op_list_t  NOCMP_OPS    = NOCMP_DFLT
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INST_W-1:0] in_word,
   output logic              out_valid,
   output logic              out_ok,
   output logic [CMP_W-1:0]  out_word
);
   localparam ctrl_tab_t CTRL_TAB = NEWER ? CTRL_TAB_NEW : CTRL_TAB_OLD;
   localparam dt_tab_t   DT_TAB   = NEWER ? DT_TAB_NEW   : DT_TAB_OLD;
   localparam sr_tab_t   SR_TAB   = NEWER ? SR_TAB_NEW   : SR_TAB_OLD;
   localparam src_tab_t  SRC_TAB  = NEWER ? SRC_TAB_NEW  : SRC_TAB_OLD;

   // elaboration-time parameter checks
   if (N_ENT != (1 << IDX_W)) begin : g_bad_depth
      $error("table depth must equal 2**IDX_W");
   end
   if (CW_S1R + REG_W != CMP_W) begin : g_bad_layout
      $error("compact field layout does not fill the compact word");
   end
   for (genvar g = 0; g < N_ENT; g++) begin : g_chk_old
      if (CTRL_TAB_OLD[g][CTRL_W-1:CTRL_W_OLD] != '0) begin : g_bad_old
         $error("older control table entry uses bits above the 17-bit key");
      end
   end

   fields_t          fld;
   logic             excluded;
   logic             ctrl_hit, dt_hit, sr_hit, s0_hit, s1_hit;
   logic [IDX_W-1:0] ctrl_idx, dt_idx, sr_idx, s0_idx, s1_idx, s1_sel;
   logic             s1_ok, gates_ok, success;
   logic [CMP_W-1:0] packed_word;

   cmpct_key_extract #(.NEWER(NEWER), .NOCMP_OPS(NOCMP_OPS)) i_extract (
      .in_word  (in_word),
      .fld      (fld),
      .excluded (excluded)
   );

   cmpct_lut_match #(.KEY_W(CTRL_W), .N(N_ENT), .IW(IDX_W), .TAB(CTRL_TAB)) i_m_ctrl (
      .key (fld.ctrl_key), .hit (ctrl_hit), .idx (ctrl_idx)
   );
   cmpct_lut_match #(.KEY_W(DT_W), .N(N_ENT), .IW(IDX_W), .TAB(DT_TAB)) i_m_dt (
      .key (fld.dt_key), .hit (dt_hit), .idx (dt_idx)
   );
   cmpct_lut_match #(.KEY_W(SR_W), .N(N_ENT), .IW(IDX_W), .TAB(SR_TAB)) i_m_sr (
      .key (fld.sr_key), .hit (sr_hit), .idx (sr_idx)
   );
   cmpct_lut_match #(.KEY_W(SRC_W), .N(N_ENT), .IW(IDX_W), .TAB(SRC_TAB)) i_m_s0 (
      .key (fld.s0_key), .hit (s0_hit), .idx (s0_idx)
   );
   cmpct_lut_match #(.KEY_W(SRC_W), .N(N_ENT), .IW(IDX_W), .TAB(SRC_TAB)) i_m_s1 (
      .key (fld.s1_key), .hit (s1_hit), .idx (s1_idx)
   );

   // an immediate replaces the source-1 lookup
   assign s1_sel = fld.imm_present ? fld.imm_idx : s1_idx;
   assign s1_ok  = fld.imm_present ? fld.imm_fits : s1_hit;

   assign gates_ok = !excluded && !fld.pre_cmpt;
   assign success  = gates_ok && ctrl_hit && dt_hit && sr_hit && s0_hit && s1_ok;

   cmpct_word_pack #(.NEWER(NEWER)) i_pack (
      .opc      (fld.opc),
      .dbg      (fld.dbg),
      .ctrl_idx (ctrl_idx),
      .dt_idx   (dt_idx),
      .sr_idx   (sr_idx),
      .acc      (fld.acc),
      .cond     (fld.cond),
      .fsub     (fld.fsub),
      .s0_idx   (s0_idx),
      .s1_idx   (s1_sel),
      .dreg     (fld.dreg),
      .s0reg    (fld.s0reg),
      .s1reg    (fld.s1reg),
      .word     (packed_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ok    <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         out_ok    <= in_valid && success;
         if (in_valid && success) out_word <= packed_word;
      end
   end
endmodule

// File: rtl/cmpct_encoder_chk.sv
module cmpct_encoder_chk
   import cmpct_pkg::*;
#(
   parameter bit       NEWER     = 1'b1,
   parameter op_list_t NOCMP_OPS = NOCMP_DFLT
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [INST_W-1:0] in_word,
   input logic              out_valid,
   input logic              out_ok,
   input logic [CMP_W-1:0]  out_word
);
   logic in_imm, in_imm_bad, in_excl;
   logic unused_in;

   assign in_imm     = (in_word[42:41] == 2'b11) || (in_word[44:43] == 2'b11);
   assign in_imm_bad = in_imm && !((in_word[127:108] == 20'hFFFFF) || (in_word[127:108] == 20'h0));
   always_comb begin
      in_excl = 1'b0;
      for (int i = 0; i < N_NOCMP; i++)
         if (in_word[6:0] == NOCMP_OPS[i]) in_excl = 1'b1;
   end
   assign unused_in = ^in_word;

   a_r14_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r14_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r14_ok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_ok |-> out_valid);
   a_r6_hold_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ok) |-> (out_word == $past(out_word)));
   a_r10_excluded_op: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_excl) |=> !out_ok);
   a_r11_already_compact: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[29]) |=> !out_ok);
   a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      out_ok |-> out_word[29]);
   a_r8_imm_range: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_imm_bad) |=> !out_ok);
   a_r13_opcode_copy: assert property (@(posedge clk) disable iff (!rst_n)
      out_ok |-> (out_word[6:0] == $past(in_word[6:0])));
   a_r12_newer_no_fsub: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ok && NEWER) |-> !out_word[28]);
endmodule

bind cmpct_encoder cmpct_encoder_chk #(.NEWER(NEWER), .NOCMP_OPS(NOCMP_OPS)) i_chk (.*);

// File: tb/test_cmpct_encoder.sv
`timescale 1ns/1ps
module test_cmpct_encoder;
   import cmpct_pkg::*;

   // bench-owned tables
   function automatic logic [18:0] ce(input int i, input bit nw);
      return nw ? {2'(i), 17'(i * 37 + 5)} : 19'(i * 37 + 5);
   endfunction
   function automatic logic [17:0] de(input int i);
      logic [17:0] e;
      e = {3'(i), 15'(i * 5)};
      if (i >= 28) e[10:9] = 2'b11;
      return e;
   endfunction
   function automatic logic [14:0] se(input int i);
      return (i < 16) ? 15'(i * 9 + 1) : 15'((i << 10) | (i * 3));
   endfunction
   function automatic logic [11:0] re(input int i);
      return 12'(((i == 20) ? 5 : i) * 101 + 7);   // entry 20 duplicates entry 5 (R7)
   endfunction
   function automatic ctrl_tab_t t_ctrl(input bit nw);
      ctrl_tab_t t;
      for (int i = 0; i < 32; i++) t[i] = ce(i, nw);
      return t;
   endfunction
   function automatic dt_tab_t t_dt();
      dt_tab_t t;
      for (int i = 0; i < 32; i++) t[i] = de(i);
      return t;
   endfunction
   function automatic sr_tab_t t_sr();
      sr_tab_t t;
      for (int i = 0; i < 32; i++) t[i] = se(i);
      return t;
   endfunction
   function automatic src_tab_t t_src();
      src_tab_t t;
      for (int i = 0; i < 32; i++) t[i] = re(i);
      return t;
   endfunction

   localparam ctrl_tab_t TB_CTRL_OLD = t_ctrl(1'b0);
   localparam ctrl_tab_t TB_CTRL_NEW = t_ctrl(1'b1);
   localparam dt_tab_t   TB_DT       = t_dt();
   localparam sr_tab_t   TB_SR       = t_sr();
   localparam src_tab_t  TB_SRC      = t_src();

   typedef struct packed {
      logic [6:0]  op;
      logic [4:0]  ci;
      logic [4:0]  di;
      logic [4:0]  si;
      logic [4:0]  s0;
      logic [4:0]  s1;
      logic [31:0] imm;
      logic [3:0]  cond;
      logic        dbg;
      logic        acc;
      logic        fsub;
      logic        pre;
      logic        ok;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{7'h01, 5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{7'h10, 5'd31, 5'd27, 5'd15, 5'd31, 5'd31, 32'h0,        4'hA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
      '{7'h05, 5'd7,  5'd3,  5'd20, 5'd12, 5'd19, 32'h0,        4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
      '{7'h33, 5'd16, 5'd9,  5'd31, 5'd1,  5'd30, 32'h0,        4'h7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      '{7'h40, 5'd2,  5'd28, 5'd4,  5'd6,  5'd0,  32'h00000ABC, 4'h1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      '{7'h41, 5'd9,  5'd30, 5'd11, 5'd1,  5'd0,  32'hFFFFF3C5, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{7'h40, 5'd2,  5'd29, 5'd4,  5'd6,  5'd0,  32'h00101000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h42, 5'd3,  5'd30, 5'd5,  5'd7,  5'd0,  32'hFFFEF000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h43, 5'd4,  5'd31, 5'd18, 5'd2,  5'd0,  32'h00000010, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h22, 5'd1,  5'd1,  5'd1,  5'd1,  5'd1,  32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h2A, 5'd1,  5'd1,  5'd1,  5'd1,  5'd1,  32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h01, 5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{7'h27, 5'd2,  5'd2,  5'd2,  5'd2,  5'd2,  32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7'h11, 5'd5,  5'd6,  5'd7,  5'd20, 5'd20, 32'h0,        4'h5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
   };

   function automatic string req_of(input int i);
      case (i)
         0, 1, 2: return "R2/R3/R4/R5/R11/R12/R13";
         3:       return "R4/R5";
         4, 5:    return "R8/R9";
         6, 7:    return "R8/R6";
         8:       return "R4/R6";
         9, 10, 12: return "R10";
         11:      return "R11";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [7:0] dreg_of(input vec_t v);  return {1'b0, v.op} ^ 8'h5A;   endfunction
   function automatic logic [7:0] s0reg_of(input vec_t v); return {3'b0, v.ci} + 8'd100; endfunction
   function automatic logic [7:0] s1reg_of(input vec_t v); return {3'b0, v.si} ^ 8'hC3;  endfunction

   function automatic logic [127:0] build(input vec_t v, input bit nw);
      logic [127:0] w;
      logic [18:0]  ck;
      logic [17:0]  dk;
      logic [14:0]  sk;
      logic         im;
      w  = '0;
      im = (v.di >= 28);
      ck = ce(int'(v.ci), nw);
      dk = de(int'(v.di));
      sk = se(int'(v.si));
      w[6:0]   = v.op;
      w[30]    = v.dbg;
      w[29]    = v.pre;
      w[28]    = v.acc;
      w[27:24] = v.cond;
      w[31]    = ck[16];
      w[23:8]  = ck[15:0];
      if (nw) w[90:89] = ck[18:17];
      else    w[89]    = v.fsub;
      w[63:61] = dk[17:15];
      w[46:32] = dk[14:0];
      w[52:48] = sk[4:0];
      w[68:64] = sk[9:5];
      w[60:53] = dreg_of(v);
      w[76:69] = s0reg_of(v);
      w[88:77] = re(int'(v.s0));
      if (im) begin
         w[127:96] = v.imm;
      end else begin
         w[100:96]  = sk[14:10];
         w[108:101] = s1reg_of(v);
         w[120:109] = re(int'(v.s1));
      end
      return w;
   endfunction

   function automatic logic [4:0] fix(input logic [4:0] x);
      return (x == 5'd20) ? 5'd5 : x;
   endfunction

   function automatic logic [63:0] exp_word(input vec_t v, input bit nw);
      logic [63:0] c;
      logic        im;
      im = (v.di >= 28);
      c = '0;
      c[6:0]   = v.op;
      c[7]     = v.dbg;
      c[12:8]  = v.ci;
      c[17:13] = v.di;
      c[22:18] = v.si;
      c[23]    = v.acc;
      c[27:24] = v.cond;
      c[28]    = nw ? 1'b0 : v.fsub;
      c[29]    = 1'b1;
      c[34:30] = fix(v.s0);
      c[39:35] = im ? v.imm[12:8] : fix(v.s1);
      c[47:40] = dreg_of(v);
      c[55:48] = s0reg_of(v);
      c[63:56] = im ? v.imm[7:0] : s1reg_of(v);
      return c;
   endfunction

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] wo = '0, wn = '0;
   logic         vo, oko, vn, okn;
   logic [63:0]  co, cn;
   logic [63:0]  last_o = '0, last_n = '0;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   cmpct_encoder #(.NEWER(1'b0), .CTRL_TAB_OLD(TB_CTRL_OLD), .CTRL_TAB_NEW(TB_CTRL_NEW),
      .DT_TAB_OLD(TB_DT), .DT_TAB_NEW(TB_DT), .SR_TAB_OLD(TB_SR), .SR_TAB_NEW(TB_SR),
      .SRC_TAB_OLD(TB_SRC), .SRC_TAB_NEW(TB_SRC)) i_cmpct_encoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(wo),
      .out_valid(vo), .out_ok(oko), .out_word(co));

   cmpct_encoder #(.NEWER(1'b1), .CTRL_TAB_OLD(TB_CTRL_OLD), .CTRL_TAB_NEW(TB_CTRL_NEW),
      .DT_TAB_OLD(TB_DT), .DT_TAB_NEW(TB_DT), .SR_TAB_OLD(TB_SR), .SR_TAB_NEW(TB_SR),
      .SRC_TAB_OLD(TB_SRC), .SRC_TAB_NEW(TB_SRC)) i_cmpct_encoder_new (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(wn),
      .out_valid(vn), .out_ok(okn), .out_word(cn));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      wo = a;
      wn = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // checks one variant's result; ok_exp=0 means the word must hold
   task automatic judge(input string req, input bit nw, input logic ok_exp, input logic [63:0] w_exp);
      chk({req, " valid R14"}, nw ? 64'(vn) : 64'(vo), 64'd1);
      chk({req, " ok"}, nw ? 64'(okn) : 64'(oko), 64'(ok_exp));
      if (ok_exp) begin
         chk({req, " word"}, nw ? cn : co, w_exp);
         if (nw) last_n = w_exp; else last_o = w_exp;
      end else begin
         chk({req, " word held R6"}, nw ? cn : co, nw ? last_n : last_o);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(10 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [127:0] a, b;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", {63'd0, vo}, 64'd0);
      chk("R1 ok", {63'd0, oko}, 64'd0);
      chk("R1 word", co, 64'd0);
      chk("R1 word new", cn, 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(build(VECS[i], 1'b0), build(VECS[i], 1'b1));
         judge(req_of(i), 1'b0, VECS[i].ok, exp_word(VECS[i], 1'b0));
         judge(req_of(i), 1'b1, VECS[i].ok, exp_word(VECS[i], 1'b1));
      end

      // R2: control key misses in each variant
      a = build(VECS[0], 1'b0); a[31] = 1'b1; a[23:8] = 16'hFFFF;
      b = build(VECS[0], 1'b1); b[90:89] = 2'b11;
      apply(a, b);
      judge("R2 ctrl miss", 1'b0, 1'b0, '0);
      judge("R2 upper ctrl bits miss", 1'b1, 1'b0, '0);

      // R2/R12: older variant ignores bit 90 in its key, copies bit 89
      a = build(VECS[1], 1'b0); a[90] = 1'b1;
      apply(a, build(VECS[1], 1'b1));
      judge("R12 older ignores bit 90", 1'b0, 1'b1, exp_word(VECS[1], 1'b0));
      judge("R12 newer flag bit clear", 1'b1, 1'b1, exp_word(VECS[1], 1'b1));

      // R3: datatype miss
      a = build(VECS[0], 1'b0); a[45] = 1'b1;
      b = build(VECS[0], 1'b1); b[45] = 1'b1;
      apply(a, b);
      judge("R3 datatype miss", 1'b0, 1'b0, '0);
      judge("R3 datatype miss", 1'b1, 1'b0, '0);

      // R4: subregister miss
      a = build(VECS[0], 1'b0); a[67] = 1'b1;
      b = build(VECS[0], 1'b1); b[67] = 1'b1;
      apply(a, b);
      judge("R4 subreg miss", 1'b0, 1'b0, '0);
      judge("R4 subreg miss", 1'b1, 1'b0, '0);

      // R5: source-0 and source-1 misses
      a = build(VECS[2], 1'b0); a[88:77] = 12'hFFF;
      b = build(VECS[2], 1'b1); b[120:109] = 12'hFFF;
      apply(a, b);
      judge("R5 src0 miss", 1'b0, 1'b0, '0);
      judge("R5 src1 miss", 1'b1, 1'b0, '0);

      // R14: idle cycle gives no valid
      @(negedge clk);
      chk("R14 idle valid", {63'd0, vo}, 64'd0);
      chk("R14 idle ok", {63'd0, okn}, 64'd0);

      // R1: reset in mid-run clears the word
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run word", co, 64'd0);
      chk("R1 mid-run ok", {63'd0, okn}, 64'd0);
      rst_n = 1'b1;

      done = 1'b1;
      finish_run();
   end
endmodule